// File: doc/BRIEF.md
# DRAM Refresh Request Scheduler

This block tells a memory controller's command arbiter when an auto-refresh is owed. A free-running interval timer, sized from the controller clock frequency, marks the end of every average refresh interval (7.8125 µs). Each interval end adds one owed refresh to a pending count. Each acknowledge from the arbiter, pulsed when it has issued a refresh, removes one.

The arbiter may postpone refreshes to serve traffic. The request output stays high while any refresh is owed. Once eight are owed, the urgent output rises: the arbiter must then service refreshes before the next interval ends, so that the gap between refreshes never grows past nine average intervals (70.3 µs). The count saturates at nine and further interval ends are dropped. Issuing the refresh command and closing banks are left to the controller.

Top module: `refresh_scheduler`

## Requirements
- R1: While `rst` is high at a rising edge, the pending count and the interval timer clear, so `refresh_req` and `refresh_urgent` read 0 after that edge.
- R2: The interval length is floor(CLK_KHZ × 78125 / 10^7) cycles. After reset is released, the pending count is incremented at every INTERVAL-th rising edge. The first increment comes at the INTERVAL-th edge with `rst` low, and `refresh_req` is high right after that edge.
- R3: An `refresh_ack` pulse sampled at a rising edge with no interval end at that edge lowers the pending count by one. `refresh_req` is high exactly when the count is nonzero. An acknowledge with a count of zero is ignored.
- R4: When an interval end and an `refresh_ack` fall on the same rising edge, the pending count is left unchanged.
- R5: `refresh_urgent` is high exactly when the pending count is 8 or more. Whenever it is high, `refresh_req` is also high.
- R6: The pending count never exceeds 9. An interval end without an acknowledge at a count of 9 leaves it at 9, so after saturation exactly nine acknowledges clear `refresh_req`.
- R7: The interval timer keeps running across acknowledges. An acknowledge does not shift the position of later interval ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| refresh_ack | input | 1 | One-cycle pulse: arbiter has issued one refresh |
| refresh_req | output | 1 | At least one refresh is owed |
| refresh_urgent | output | 1 | Eight or more refreshes owed; service before the next interval end |

## Verification
An interval end and an arbiter acknowledge can land on the same clock edge. There, the pending count must neither rise nor fall. The bench keeps its own interval counter and lines up an acknowledge with the exact edge on which that counter expires, starting from one owed refresh. It then judges the result at the ports: `refresh_req` must stay high, and must fall after exactly one further acknowledge. Random acknowledges also land on interval ends many times, and each time the bench's own count is compared with both outputs.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

    localparam int unsigned PEND_W    = 4;
    localparam int unsigned PEND_MAX  = 9;
    localparam int unsigned URGENT_AT = 8;

    typedef logic [PEND_W-1:0] pend_t;

    typedef enum logic [1:0] {
        EV_NONE = 2'b00,
        EV_TICK = 2'b01,
        EV_ACK  = 2'b10,
        EV_BOTH = 2'b11
    } evt_e;

    typedef struct packed {
        logic req;
        logic urgent;
    } flags_t;

    // Cycles per average refresh interval of 7.8125 us, rounded down.
    function automatic int unsigned interval_cycles(int unsigned khz);
        longint unsigned prod;
        prod = longint'(khz) * 64'd78125;
        return int'(prod / 64'd10000000);
    endfunction

    function automatic evt_e make_evt(logic tick, logic ack);
        return evt_e'({ack, tick});
    endfunction

    function automatic pend_t pend_next(pend_t p, evt_e e);
        pend_t r;
        r = p;
        case (e)
            EV_TICK: if (p < pend_t'(PEND_MAX)) r = p + pend_t'(1);
            EV_ACK:  if (p != pend_t'(0))       r = p - pend_t'(1);
            default: r = p;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/refsched_timer.sv
module refsched_timer #(
    parameter int unsigned INTERVAL = 1562
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

    logic [TW-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + TW'(1);
    end

    // R2: the counter wraps to zero right after an interval end
    assert_tick_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == '0));

    // R7: the counter only moves forward by one between interval ends
    assert_timer_step_R7: assert property (@(posedge clk) disable iff (rst)
        !tick |=> (cnt == $past(cnt) + TW'(1)));

endmodule

// File: rtl/refsched_pending.sv
module refsched_pending
    import refsched_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  ack,
    output pend_t pend
);
    evt_e  evt;
    pend_t pend_d;

    assign evt    = make_evt(tick, ack);
    assign pend_d = pend_next(pend, evt);

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= pend_d;
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        pend <= pend_t'(PEND_MAX));

    assert_tick_inc_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && !ack && pend < pend_t'(PEND_MAX)) |=> (pend == $past(pend) + pend_t'(1)));

    assert_ack_dec_R3: assert property (@(posedge clk) disable iff (rst)
        (ack && !tick && pend != '0) |=> (pend == $past(pend) - pend_t'(1)));

    assert_ack_empty_R3: assert property (@(posedge clk) disable iff (rst)
        (ack && !tick && pend == '0) |=> (pend == '0));

    assert_both_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (ack && tick) |=> $stable(pend));

    assert_sat_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (tick && !ack && pend == pend_t'(PEND_MAX)) |=> (pend == pend_t'(PEND_MAX)));

endmodule

// File: rtl/refsched_flags.sv
module refsched_flags
    import refsched_pkg::*;
(
    input  pend_t  pend,
    output flags_t flags
);
    always_comb begin
        flags.req    = (pend != '0);
        flags.urgent = (pend >= pend_t'(URGENT_AT));
    end
endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler
    import refsched_pkg::*;
#(
    parameter int unsigned CLK_KHZ = 200000
) (
    input  logic clk,
    input  logic rst,
    input  logic refresh_ack,
    output logic refresh_req,
    output logic refresh_urgent
);
    localparam int unsigned INTERVAL = interval_cycles(CLK_KHZ);

    logic   tick;
    pend_t  pend;
    flags_t flags;

    refsched_timer #(.INTERVAL(INTERVAL)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    refsched_pending u_pending (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .ack  (refresh_ack),
        .pend (pend)
    );

    refsched_flags u_flags (
        .pend  (pend),
        .flags (flags)
    );

    assign refresh_req    = flags.req;
    assign refresh_urgent = flags.urgent;

    // R5: urgency never appears without a request
    assert_urgent_has_req_R5: assert property (@(posedge clk) disable iff (rst)
        refresh_urgent |-> refresh_req);

    // R1: outputs are quiet on the cycle after a reset edge
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!refresh_req && !refresh_urgent));

endmodule

// File: tb/refresh_scheduler_test.sv
`timescale 1ns/1ps
module refresh_scheduler_test;

    localparam int unsigned KHZ = 2048;
    localparam int          IV  = 16;   // floor(2048 * 78125 / 1e7)

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ack = 1'b0;
    logic req, urg;

    int errors = 0;
    int checks = 0;
    int m_cnt  = 0;
    int m_pend = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    refresh_scheduler #(.CLK_KHZ(KHZ)) uut (
        .clk            (clk),
        .rst            (rst),
        .refresh_ack    (ack),
        .refresh_req    (req),
        .refresh_urgent (urg)
    );

    function automatic int exp_next(int p, bit t, bit a);
        if (t && !a) return (p < 9) ? p + 1 : p;
        if (a && !t) return (p > 0) ? p - 1 : p;
        return p;
    endfunction

    task automatic check(bit act, bit exp, string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b (model pend=%0d)", tag, act, exp, m_pend);
        end
    endtask

    task automatic compare_all();
        check(req, m_pend != 0, "R3 refresh_req");
        check(urg, m_pend >= 8, "R5 refresh_urgent");
    endtask

    // one clock: drive ack, update model at the edge, compare at negedge
    task automatic step(bit a);
        bit t;
        ack = a;
        @(posedge clk);
        if (rst) begin
            m_cnt = 0; m_pend = 0;
        end else begin
            t = (m_cnt == IV - 1);
            m_cnt = t ? 0 : m_cnt + 1;
            m_pend = exp_next(m_pend, t, a);
        end
        @(negedge clk);
        ack = 1'b0;
        compare_all();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(0);
        step(0);
        check(req, 1'b0, "R1 req in reset");
        check(urg, 1'b0, "R1 urgent in reset");
        rst = 1'b0;
    endtask

    task automatic align_tick();
        while (m_cnt != IV - 1) step(0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R2: first request exactly IV edges after release
        for (int i = 0; i < IV - 1; i++) step(0);
        check(req, 1'b0, "R2 no request before interval end");
        step(0);
        check(req, 1'b1, "R2 request at interval end");

        // R4: tick and ack on the same edge with one owed
        align_tick();
        step(1);
        check(req, 1'b1, "R4 count held on coincident edge");
        step(1);
        check(req, 1'b0, "R4 one ack clears after coincident edge");

        // R3: ack at zero is ignored, then a tick still raises request
        step(1);
        step(1);
        check(req, 1'b0, "R3 ack at zero ignored");
        align_tick();
        step(0);
        check(req, 1'b1, "R3 tick after ignored acks");

        // R5, R6: starve to saturation
        for (int i = 0; i < 11 * IV; i++) step(0);
        check(urg, 1'b1, "R5 urgent when saturated");
        align_tick();
        step(0);                      // tick at 9: dropped
        for (int k = 0; k < 8; k++) step(1);
        check(req, 1'b1, "R6 eight acks leave one owed");
        check(urg, 1'b0, "R5 urgent drops below eight");
        step(1);
        check(req, 1'b0, "R6 nine acks clear saturated count");

        // R7: acks do not move later interval ends
        align_tick();
        step(0);
        for (int i = 0; i < IV - 1; i++) step(i == 3);
        check(req, 1'b0, "R7 ack mid-interval serviced");
        step(0);
        check(req, 1'b1, "R7 next interval end on schedule");

        // R1: reset mid-run clears the count and restarts the timer
        for (int i = 0; i < 5 * IV + 3; i++) step(0);
        do_reset();
        for (int i = 0; i < IV - 1; i++) step(0);
        check(req, 1'b0, "R1 timer restarted");
        step(0);
        check(req, 1'b1, "R1 first interval end after reset");

        // random traffic with varying ack density
        for (int ph = 0; ph < 4; ph++) begin
            for (int i = 0; i < 1500; i++) begin
                bit a;
                a = (($urandom % 64) < (ph * 3 + 1));
                step(a);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule